// File: doc/BRIEF.md
# Word-Packed Byte FIFO Pair for an I2C Controller

This block buffers data between a 32-bit register interface and a byte-serial I2C engine. Software writes whole 32-bit words into a transmit queue, and the engine pulls them out one byte at a time, lowest byte lane first. In the other direction, bytes arriving from the engine are collected into 32-bit words, lowest lane first, and software reads the finished words from a receive queue. A transfer need not be a multiple of four bytes. The engine supplies a count of the bytes left in the current transfer, including the one now on the byte port. When that count reaches one, the current word is closed early, and only its low byte lanes carry data.

A control register holds a programmable trigger level for each direction. It also holds one flush bit per direction, and each flush bit clears itself once its flush has run. A status byte reports the free word slots in the transmit queue and the filled word slots in the receive queue. Two request outputs compare these counts against the trigger levels. Two sticky error flags record a write into a full transmit queue and a read from an empty receive queue.

Top module: `i2c_word_fifo_pair`

## Requirements
- R1: After reset, the status reports 8 free transmit slots and 0 filled receive slots. Both trigger levels, both flush bits and both error flags are 0, the transmit request is high and the receive request is low.
- R2: A control write with bit 1 set (transmit flush) or bit 0 set (receive flush) makes that bit read back 1 for exactly one cycle. On the following clock edge the queue is emptied, its partial-word byte position is reset, a partly assembled receive word is discarded, and its error flag is cleared. The flush takes priority over any push, pop or error in that same cycle.
- R3: Status bits 7:4 give the number of free transmit word slots, and bits 3:0 give the number of filled receive word slots. Each field ranges from 0 to 8.
- R4: The transmit trigger level is held in control bits 7:5 and the receive trigger level in bits 4:2, and both read back as written. The transmit request is high while the free count exceeds the transmit trigger level. The receive request is high while the filled count exceeds the receive trigger level.
- R5: The transmit byte port presents the bytes of the oldest word in the order bits 7:0, 15:8, 23:16, 31:24. Each accepted handshake moves to the next lane, and the word is retired after its fourth byte.
- R6: When a transmit byte is accepted while the transmit remaining count is 1 or less, the current word is retired after that byte. Its unsent upper lanes are skipped, and the next word starts at lane 0.
- R7: Received bytes fill lanes 7:0, 15:8, 23:16, 31:24 in arrival order. The word enters the receive queue on the edge that accepts its fourth byte.
- R8: When a received byte is accepted while the receive remaining count is 1 or less, the word enters the queue at once, and the lanes above that byte read as zero.
- R9: A word write while the transmit queue holds 8 words is dropped and sets the transmit overflow flag. The flag stays set until a transmit flush.
- R10: A read while the receive queue is empty sets the receive underflow flag and leaves the queue unchanged. The flag stays set until a receive flush. The read-data port shows zero while the queue is empty and the oldest word otherwise.
- R11: The transmit byte-valid output is low exactly when the transmit queue is empty. The receive byte-ready output is low exactly when the receive queue is full. An offered transmit byte stays stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data: trigger levels and flush bits |
| ctl_rdata | output | 8 | Control readback |
| stat_rdata | output | 8 | Free transmit slots (7:4), filled receive slots (3:0) |
| txw_wr | input | 1 | Transmit word write strobe |
| txw_data | input | 32 | Transmit word |
| rxw_rd | input | 1 | Receive word read strobe (pops the oldest word) |
| rxw_data | output | 32 | Oldest receive word, zero when empty |
| tx_req | output | 1 | Transmit data request |
| rx_req | output | 1 | Receive data request |
| tx_ovf | output | 1 | Sticky transmit overflow flag |
| rx_unf | output | 1 | Sticky receive underflow flag |
| tx_byte_valid | output | 1 | Transmit byte offered to the engine |
| tx_byte | output | 8 | Transmit byte |
| tx_byte_ready | input | 1 | Engine accepts the transmit byte |
| tx_remain | input | 16 | Bytes left in the transmit transfer, including the current one |
| rx_byte_valid | input | 1 | Engine offers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_byte_ready | output | 1 | Receive side can accept a byte |
| rx_remain | input | 16 | Bytes left in the receive transfer, including the current one |

## Verification
Every strobe and handshake is captured on one rising edge. Its effect on the counts, flags, request outputs, byte port and read-data port is visible right after that same edge, so a result is due one cycle after its stimulus. The one exception is a flush: its bit shows as 1 after the write edge, and the emptied queue and cleared flag appear only after the next edge. The bench drives inputs on the falling edge and compares every output with a queue-based model at the following falling edge. The model applies each edge's inputs in the priority order the requirements state.

// File: rtl/i2c_wf_pkg.sv
package i2c_wf_pkg;
   localparam int BYTE_W = 8;
   localparam int LANES  = 4;
   localparam int WORD_W = BYTE_W * LANES;
   localparam int LANE_W = $clog2(LANES);
   localparam int TRIG_W = 3;
   localparam int STAT_W = 4;

   // control register layout (decoded by software)
   localparam int CTL_RX_FLUSH = 0;
   localparam int CTL_TX_FLUSH = 1;
   localparam int CTL_RX_TRIG  = 2;
   localparam int CTL_TX_TRIG  = 5;

   typedef logic [WORD_W-1:0] word_t;
   typedef logic [LANE_W-1:0] lane_t;
   typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/i2c_wf_word_fifo.sv
module i2c_wf_word_fifo
   import i2c_wf_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  word_t         wdata,
   input  logic          pop,
   output word_t         rdata,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   localparam bit POW2 = ((1 << AW) == DEPTH);

   word_t          mem [DEPTH];
   logic [AW-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic           do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign rdata   = mem[rd_ptr];

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/i2c_wf_tx_unpack.sv
module i2c_wf_tx_unpack
   import i2c_wf_pkg::*;
#(
   parameter int REM_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  word_t            head,
   input  logic             fifo_empty,
   input  logic [REM_W-1:0] remain,
   input  logic             byte_ready,
   output logic             byte_valid,
   output byte_t            byte_out,
   output logic             word_pop
);
   lane_t lane;
   byte_t lane_bytes [LANES];
   logic  take, last;

   genvar gi;
   generate
      for (gi = 0; gi < LANES; gi++) begin : g_lane
         assign lane_bytes[gi] = head[gi*BYTE_W +: BYTE_W];
      end
   endgenerate

   assign byte_valid = !fifo_empty;
   assign byte_out   = lane_bytes[lane];
   assign take       = byte_valid && byte_ready;
   assign last       = (lane == LANE_W'(LANES - 1)) || (remain <= REM_W'(1));
   assign word_pop   = take && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lane <= '0;
      else if (flush)    lane <= '0;
      else if (word_pop) lane <= '0;
      else if (take)     lane <= lane + 1'b1;
   end
endmodule

// File: rtl/i2c_wf_rx_pack.sv
module i2c_wf_rx_pack
   import i2c_wf_pkg::*;
#(
   parameter int REM_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             byte_valid,
   input  byte_t            byte_in,
   input  logic [REM_W-1:0] remain,
   input  logic             fifo_full,
   output logic             byte_ready,
   output logic             word_push,
   output word_t            word_out
);
   lane_t lane;
   byte_t acc [LANES];
   logic  take, last;

   assign byte_ready = !fifo_full;
   assign take       = byte_valid && byte_ready;
   assign last       = (lane == LANE_W'(LANES - 1)) || (remain <= REM_W'(1));
   assign word_push  = take && last;

   genvar gi;
   generate
      for (gi = 0; gi < LANES; gi++) begin : g_merge
         assign word_out[gi*BYTE_W +: BYTE_W] =
            (lane == LANE_W'(gi)) ? byte_in : acc[gi];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lane <= '0;
         for (int i = 0; i < LANES; i++) acc[i] <= '0;
      end else if (flush || word_push) begin
         lane <= '0;
         for (int i = 0; i < LANES; i++) acc[i] <= '0;
      end else if (take) begin
         acc[lane] <= byte_in;
         lane      <= lane + 1'b1;
      end
   end
endmodule

// File: rtl/i2c_word_fifo_pair.sv
module i2c_word_fifo_pair
   import i2c_wf_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int REM_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [7:0]       ctl_wdata,
   output logic [7:0]       ctl_rdata,
   output logic [7:0]       stat_rdata,
   input  logic             txw_wr,
   input  logic [31:0]      txw_data,
   input  logic             rxw_rd,
   output logic [31:0]      rxw_data,
   output logic             tx_req,
   output logic             rx_req,
   output logic             tx_ovf,
   output logic             rx_unf,
   output logic             tx_byte_valid,
   output logic [7:0]       tx_byte,
   input  logic             tx_byte_ready,
   input  logic [REM_W-1:0] tx_remain,
   input  logic             rx_byte_valid,
   input  logic [7:0]       rx_byte,
   output logic             rx_byte_ready,
   input  logic [REM_W-1:0] rx_remain
);
   localparam int CW = $clog2(DEPTH + 1);

   initial begin
      assert (DEPTH >= 2 && DEPTH < (1 << STAT_W))
         else $error("DEPTH must fit the status count field");
      assert (REM_W >= 1) else $error("REM_W must be at least 1");
   end

   logic [TRIG_W-1:0] tx_trig, rx_trig;
   logic              tx_fpend, rx_fpend;
   logic [CW-1:0]     tx_cnt, rx_cnt;
   logic              tx_full, tx_empty, rx_full, rx_empty;
   logic              tx_pop, rx_push;
   word_t             tx_head, rx_head, rx_word;
   logic [STAT_W-1:0] tx_free, rx_fill;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_trig  <= '0;
         rx_trig  <= '0;
         tx_fpend <= 1'b0;
         rx_fpend <= 1'b0;
      end else begin
         tx_fpend <= ctl_wr && ctl_wdata[CTL_TX_FLUSH];
         rx_fpend <= ctl_wr && ctl_wdata[CTL_RX_FLUSH];
         if (ctl_wr) begin
            tx_trig <= ctl_wdata[CTL_TX_TRIG +: TRIG_W];
            rx_trig <= ctl_wdata[CTL_RX_TRIG +: TRIG_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_ovf <= 1'b0;
         rx_unf <= 1'b0;
      end else begin
         if (tx_fpend)                tx_ovf <= 1'b0;
         else if (txw_wr && tx_full)  tx_ovf <= 1'b1;
         if (rx_fpend)                rx_unf <= 1'b0;
         else if (rxw_rd && rx_empty) rx_unf <= 1'b1;
      end
   end

   i2c_wf_word_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
      .clk(clk), .rst_n(rst_n), .flush(tx_fpend),
      .push(txw_wr), .wdata(txw_data), .pop(tx_pop), .rdata(tx_head),
      .count(tx_cnt), .full(tx_full), .empty(tx_empty)
   );

   i2c_wf_tx_unpack #(.REM_W(REM_W)) u_tx_unpack (
      .clk(clk), .rst_n(rst_n), .flush(tx_fpend),
      .head(tx_head), .fifo_empty(tx_empty), .remain(tx_remain),
      .byte_ready(tx_byte_ready), .byte_valid(tx_byte_valid),
      .byte_out(tx_byte), .word_pop(tx_pop)
   );

   i2c_wf_rx_pack #(.REM_W(REM_W)) u_rx_pack (
      .clk(clk), .rst_n(rst_n), .flush(rx_fpend),
      .byte_valid(rx_byte_valid), .byte_in(rx_byte), .remain(rx_remain),
      .fifo_full(rx_full), .byte_ready(rx_byte_ready),
      .word_push(rx_push), .word_out(rx_word)
   );

   i2c_wf_word_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
      .clk(clk), .rst_n(rst_n), .flush(rx_fpend),
      .push(rx_push), .wdata(rx_word), .pop(rxw_rd), .rdata(rx_head),
      .count(rx_cnt), .full(rx_full), .empty(rx_empty)
   );

   assign tx_free    = STAT_W'(DEPTH) - STAT_W'(tx_cnt);
   assign rx_fill    = STAT_W'(rx_cnt);
   assign stat_rdata = {tx_free, rx_fill};
   assign ctl_rdata  = {tx_trig, rx_trig, tx_fpend, rx_fpend};
   assign tx_req     = (tx_free > STAT_W'(tx_trig));
   assign rx_req     = (rx_fill > STAT_W'(rx_trig));
   assign rxw_data   = rx_empty ? '0 : rx_head;
endmodule

// File: rtl/i2c_wf_checker.sv
module i2c_wf_checker #(
   parameter int DEPTH = 8
) (
   input logic        clk,
   input logic        rst_n,
   input logic [7:0]  ctl_rdata,
   input logic [7:0]  stat_rdata,
   input logic        txw_wr,
   input logic        rxw_rd,
   input logic        tx_ovf,
   input logic        rx_unf,
   input logic        tx_byte_valid,
   input logic [7:0]  tx_byte,
   input logic        tx_byte_ready,
   input logic        rx_byte_ready
);
   p_tx_flush_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[1] |=> (stat_rdata[7:4] == 4'(DEPTH)) && !tx_ovf);

   p_rx_flush_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[0] |=> (stat_rdata[3:0] == 4'd0) && !rx_unf);

   p_count_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rdata[7:4] <= 4'(DEPTH)) && (stat_rdata[3:0] <= 4'(DEPTH)));

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (txw_wr && stat_rdata[7:4] == 4'd0 && !ctl_rdata[1]) |=> tx_ovf);

   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ovf && !ctl_rdata[1]) |=> tx_ovf);

   p_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rxw_rd && stat_rdata[3:0] == 4'd0 && !ctl_rdata[0]) |=> rx_unf);

   p_tx_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_byte_valid == (stat_rdata[7:4] != 4'(DEPTH)));

   p_rx_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_byte_ready == (stat_rdata[3:0] != 4'(DEPTH)));

   p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_byte_valid && !tx_byte_ready && !ctl_rdata[1])
         |=> tx_byte_valid && $stable(tx_byte));
endmodule

bind i2c_word_fifo_pair i2c_wf_checker #(.DEPTH(DEPTH)) u_checker (
   .clk(clk), .rst_n(rst_n), .ctl_rdata(ctl_rdata), .stat_rdata(stat_rdata),
   .txw_wr(txw_wr), .rxw_rd(rxw_rd), .tx_ovf(tx_ovf), .rx_unf(rx_unf),
   .tx_byte_valid(tx_byte_valid), .tx_byte(tx_byte),
   .tx_byte_ready(tx_byte_ready), .rx_byte_ready(rx_byte_ready)
);

// File: tb/i2c_word_fifo_pair_test.sv
module i2c_word_fifo_pair_test;
   localparam int DEPTH = 8;
   localparam int REM_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ctl_wr = 1'b0;
   logic [7:0]       ctl_wdata = '0;
   logic [7:0]       ctl_rdata, stat_rdata;
   logic             txw_wr = 1'b0;
   logic [31:0]      txw_data = '0;
   logic             rxw_rd = 1'b0;
   logic [31:0]      rxw_data;
   logic             tx_req, rx_req, tx_ovf, rx_unf;
   logic             tx_byte_valid;
   logic [7:0]       tx_byte;
   logic             tx_byte_ready = 1'b0;
   logic [REM_W-1:0] tx_remain = 16'd4;
   logic             rx_byte_valid = 1'b0;
   logic [7:0]       rx_byte = '0;
   logic             rx_byte_ready;
   logic [REM_W-1:0] rx_remain = 16'd4;

   always #4 clk = ~clk;

   i2c_word_fifo_pair #(.DEPTH(DEPTH), .REM_W(REM_W)) uut (.*);

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   // behavioural reference state
   logic [31:0] m_txq[$];
   logic [31:0] m_rxq[$];
   int          m_txl, m_rxl;
   logic [31:0] m_acc;
   logic        m_ovf, m_unf, m_txf, m_rxf;
   logic [2:0]  m_ttrig, m_rtrig;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_txq.delete(); m_rxq.delete();
         m_txl = 0; m_rxl = 0; m_acc = '0;
         m_ovf = 0; m_unf = 0; m_txf = 0; m_rxf = 0;
         m_ttrig = '0; m_rtrig = '0;
      end else begin
         automatic bit tx_full0  = (m_txq.size() == DEPTH);
         automatic bit rx_full0  = (m_rxq.size() == DEPTH);
         automatic bit rx_empty0 = (m_rxq.size() == 0);
         if (m_txf) begin
            m_txq.delete(); m_txl = 0; m_ovf = 0;
         end else begin
            if (m_txq.size() > 0 && tx_byte_ready) begin
               if (m_txl == 3 || tx_remain <= 1) begin
                  void'(m_txq.pop_front()); m_txl = 0;
               end else m_txl++;
            end
            if (txw_wr) begin
               if (tx_full0) m_ovf = 1;
               else m_txq.push_back(txw_data);
            end
         end
         if (m_rxf) begin
            m_rxq.delete(); m_rxl = 0; m_acc = '0; m_unf = 0;
         end else begin
            if (rxw_rd) begin
               if (rx_empty0) m_unf = 1;
               else void'(m_rxq.pop_front());
            end
            if (rx_byte_valid && !rx_full0) begin
               m_acc = m_acc | (32'(rx_byte) << (8 * m_rxl));
               if (m_rxl == 3 || rx_remain <= 1) begin
                  m_rxq.push_back(m_acc); m_acc = '0; m_rxl = 0;
               end else m_rxl++;
            end
         end
         m_txf = ctl_wr && ctl_wdata[1];
         m_rxf = ctl_wr && ctl_wdata[0];
         if (ctl_wr) begin
            m_ttrig = ctl_wdata[7:5];
            m_rtrig = ctl_wdata[4:2];
         end
      end
   end

   task automatic compare_all();
      automatic int free_n = DEPTH - m_txq.size();
      automatic int fill_n = m_rxq.size();
      automatic logic [7:0] e_ctl  = {m_ttrig, m_rtrig, m_txf, m_rxf};
      automatic logic [7:0] e_stat = {4'(free_n), 4'(fill_n)};
      automatic logic [31:0] e_rxd = (fill_n == 0) ? 32'd0 : m_rxq[0];
      chk(ctl_rdata == e_ctl, "R2/R4", "control readback", 32'(ctl_rdata), 32'(e_ctl));
      chk(stat_rdata == e_stat, "R3", "status counts", 32'(stat_rdata), 32'(e_stat));
      chk(tx_req == (free_n > int'(m_ttrig)), "R4", "tx request", 32'(tx_req), 32'(free_n > int'(m_ttrig)));
      chk(rx_req == (fill_n > int'(m_rtrig)), "R4", "rx request", 32'(rx_req), 32'(fill_n > int'(m_rtrig)));
      chk(tx_ovf == m_ovf, "R9", "tx overflow flag", 32'(tx_ovf), 32'(m_ovf));
      chk(rx_unf == m_unf, "R10", "rx underflow flag", 32'(rx_unf), 32'(m_unf));
      chk(tx_byte_valid == (free_n != DEPTH), "R11", "tx byte valid", 32'(tx_byte_valid), 32'(free_n != DEPTH));
      chk(rx_byte_ready == (fill_n != DEPTH), "R11", "rx byte ready", 32'(rx_byte_ready), 32'(fill_n != DEPTH));
      if (free_n != DEPTH) begin
         automatic logic [7:0] e_b = 8'(m_txq[0] >> (8 * m_txl));
         chk(tx_byte == e_b, "R5/R6", "tx byte lane order", 32'(tx_byte), 32'(e_b));
      end
      chk(rxw_data == e_rxd, "R7/R8/R10", "rx word data", rxw_data, e_rxd);
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(stat_rdata == 8'h80, "R1", "reset status", 32'(stat_rdata), 32'h80);
      chk(ctl_rdata == 8'h00, "R1", "reset control", 32'(ctl_rdata), 32'h00);
      chk(tx_req && !rx_req && !tx_ovf && !rx_unf, "R1", "reset flags",
          {28'd0, tx_req, rx_req, tx_ovf, rx_unf}, 32'h8);
      for (int cyc = 0; cyc < 6000; cyc++) begin
         automatic int ph = (cyc / 300) % 4;
         automatic int p_wr = (ph == 0) ? 60 : (ph == 1) ? 5 : 30;
         automatic int p_tr = (ph == 0) ? 10 : (ph == 1) ? 85 : 50;
         automatic int p_rv = (ph == 2) ? 85 : (ph == 3) ? 40 : 20;
         automatic int p_rd = (ph == 2) ? 5 : (ph == 3) ? 60 : 30;
         compare_all();
         cycles++;
         txw_wr        = ($urandom_range(99) < p_wr);
         txw_data      = $urandom;
         tx_byte_ready = ($urandom_range(99) < p_tr);
         tx_remain     = 16'($urandom_range(0, 6));
         rx_byte_valid = ($urandom_range(99) < p_rv);
         rx_byte       = 8'($urandom);
         rx_remain     = 16'($urandom_range(0, 6));
         rxw_rd        = ($urandom_range(99) < p_rd);
         ctl_wr        = ($urandom_range(99) < 3);
         ctl_wdata     = 8'($urandom);
         if (ph == 1 || ph == 2) ctl_wdata[1:0] = 2'b00;
         @(negedge clk);
      end
      compare_all();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule